// File: doc/BRIEF.md
# Serial Transmitter with Address-Marker Bit

This block turns bytes into asynchronous serial frames on a single output line. Each frame has one start bit, eight data bits sent least significant first, one extra marker bit, and one stop bit. The marker bit lets a receiver on a shared line tell an address byte (marker 1) from a data byte (marker 0). Software, or an external transfer engine, places a byte in a holding register. It sets the marker value and then hands the byte over by clearing an "empty" flag. The transmitter copies the byte into its shift register and sets the flag again. The next byte can therefore be loaded while the current one is still shifting out.

When transmission is switched on, the block first sends one whole frame of ones before any data. A "finished" flag reports that the last stop bit has left the line and that no byte is waiting, so software knows when it may switch the transmitter off. While the transmitter is off, the line is driven from a general-purpose port path. If software sets that port to drive a low level, the line holds a break condition. A request output stays high while the holding register is free, so a transfer engine can refill it. The engine clears the flag by itself only when its own mode and count allow it.

Top module: `mpb_uart_tx`

## Requirements
- R1: A frame is 11 bit periods. In order on the line: start bit 0, data bit 0 through data bit 7, marker bit, stop bit 1. Each bit lasts `baud_div` clocks, and a value of 0 is treated as 1.
- R2: The marker bit of a frame equals the value last written through `mpb_wr`/`mpb_val` before the byte moved into the shifter.
- R3: On the first cycle with `tx_en` high after a cycle with it low, the line stays 1 for 11 bit periods. No start bit can begin during that time, even if a byte is already handed over.
- R4: `empty_flag` is 1 after reset. A `clr_empty` pulse while the flag is 1 clears it. One clock after the shifter becomes free, the byte moves into the shifter and the flag returns to 1 while that frame is still shifting.
- R5: `end_flag` goes to 0 when the empty flag is cleared, and also when the transmitter is switched on. It goes to 1 at the end of a stop bit only if `empty_flag` is 1 at that moment. It is never 1 while a byte is waiting.
- R6: `txi_req` is 1 exactly when `tx_en` is 1 and `empty_flag` is 1.
- R7: An `xfer_wr` pulse always writes `wr_data` into the holding register. It clears the empty flag only when `xfer_dis_sel` is 0 and `xfer_cnt_nz` is 1. In every other case no frame is sent and the flag stays 1.
- R8: While `tx_en` is 0, `txd` equals `port_dat` when `port_dir` is 1, and is 1 otherwise. Setting `port_dir` to 1 with `port_dat` at 0 gives a continuous break.
- R9: Driving `tx_en` to 0 stops any frame in progress. From the next clock, `empty_flag` and `end_flag` both read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| baud_div | input | DIV_W | Clocks per bit period |
| wr_en | input | 1 | Software write strobe for the holding register |
| wr_data | input | 8 | Byte for the holding register |
| mpb_wr | input | 1 | Write strobe for the marker-bit control |
| mpb_val | input | 1 | Marker-bit value |
| clr_empty | input | 1 | Software clear of the empty flag |
| xfer_wr | input | 1 | Transfer-engine write of `wr_data` |
| xfer_dis_sel | input | 1 | Engine mode; 1 blocks the automatic flag clear |
| xfer_cnt_nz | input | 1 | Engine transfer count is nonzero |
| port_dir | input | 1 | General-purpose port drives the line when set |
| port_dat | input | 1 | General-purpose port level |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding register free |
| end_flag | output | 1 | Transmission finished |
| txi_req | output | 1 | Refill request for the transfer engine |

## Verification
The bench times the startup frame of ones exactly, with a byte already handed over. A design that skipped this frame, or sent the byte one period early, would show a start bit before cycle 46. It runs bursts of random bytes with random marker bits, back to back, at several divisor values including 1. Any fault in the bit order, a marker bit taken at the wrong time, or a lost byte during the early reload would show up as a wrong decoded frame. It tries transfer-engine writes in the two modes that must not clear the flag: a design that cleared the flag anyway would send an unexpected frame. Finally, it turns the transmitter off in the middle of a frame and drives a break. Flags left at 0, or a line not taken over by the port path, would be caught at the ports.

// File: rtl/mpt_pkg.sv
// Shared widths, frame type and frame builder for the marker-bit transmitter.
package mpt_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned FRAME_W = DATA_W + 3;   // start + data + marker + stop
    localparam int unsigned BCNT_W  = $clog2(FRAME_W + 1);

    typedef logic [DATA_W-1:0]  byte_t;
    typedef logic [FRAME_W-1:0] frame_t;

    // Builds a frame whose bit 0 leaves the line first.
    function automatic frame_t mpt_frame(input byte_t d, input logic mpb);
        return {1'b1, mpb, d, 1'b0};
    endfunction
endpackage

// File: rtl/mpt_baud.sv
// Bit-period divider: gives one tick per bit period while run is high.
// Assumes div may be 0, which is treated as 1. restart aligns a new frame.
module mpt_baud #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? '0 : div - 1'b1;
    assign tick = run && (cnt_q >= last);

    // Counts clocks inside the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) cnt_q <= '0;
        else if (tick)                 cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mpt_shifter.sv
// Frame shifter: takes an 11-bit frame on load and sends it LSB first.
// Assumes load only when busy is low; en low aborts the frame at once.
module mpt_shifter #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  mpt_pkg::frame_t  frame,
    output logic             busy,
    output logic             done,
    output logic             sh_txd
);
    import mpt_pkg::*;

    frame_t            sreg_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              busy_q;
    logic              tick;
    logic              take;

    assign take = load && !busy_q;

    mpt_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_q),
        .restart (take),
        .div     (div),
        .tick    (tick)
    );

    assign busy   = busy_q;
    assign done   = busy_q && tick && (bcnt_q == BCNT_W'(FRAME_W - 1));
    assign sh_txd = busy_q ? sreg_q[0] : 1'b1;

    // Loads a frame, then shifts one bit at each bit-period tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sreg_q <= '1;
            bcnt_q <= '0;
            busy_q <= 1'b0;
        end else if (take) begin
            sreg_q <= frame;
            bcnt_q <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && tick) begin
            sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
            if (done) begin
                bcnt_q <= '0;
                busy_q <= 1'b0;
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mpt_regs.sv
// Register side: holding register, marker control, empty/finished flags.
// Assumes software writes only while empty_flag is 1 and clears it afterwards.
module mpt_regs (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            wr_en,
    input  mpt_pkg::byte_t  wr_data,
    input  logic            mpb_wr,
    input  logic            mpb_val,
    input  logic            clr_empty,
    input  logic            xfer_wr,
    input  logic            xfer_dis_sel,
    input  logic            xfer_cnt_nz,
    input  logic            sh_busy,
    input  logic            sh_done,
    output logic            sh_load,
    output mpt_pkg::frame_t sh_frame,
    output logic            empty_flag,
    output logic            end_flag
);
    import mpt_pkg::*;

    byte_t data_q;
    logic  mpb_q;
    logic  en_q;
    logic  empty_q;
    logic  end_q;
    logic  rise;
    logic  load_dat;
    logic  hand;

    assign rise     = tx_en && !en_q;
    assign load_dat = tx_en && en_q && !sh_busy && !empty_q;
    assign hand     = empty_q && (clr_empty || (xfer_wr && !xfer_dis_sel && xfer_cnt_nz));
    assign sh_load  = rise || load_dat;
    assign sh_frame = rise ? '1 : mpt_frame(data_q, mpb_q);

    assign empty_flag = empty_q;
    assign end_flag   = end_q;

    // Remembers the previous enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= tx_en;
    end

    // Holding register, written by software or by the transfer engine.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (wr_en || xfer_wr) data_q <= wr_data;
    end

    // Marker-bit control value for the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      mpb_q <= 1'b0;
        else if (mpb_wr) mpb_q <= mpb_val;
    end

    // Empty and finished flags; a hand-over overrides every other update.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            empty_q <= 1'b1;
            end_q   <= 1'b1;
        end else begin
            if (rise)              end_q   <= 1'b0;
            if (sh_done && empty_q) end_q  <= 1'b1;
            if (load_dat)          empty_q <= 1'b1;
            if (hand) begin
                empty_q <= 1'b0;
                end_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpb_uart_tx.sv
// Top: serial transmitter with marker bit, refill request and port fallback.
// Assumes all inputs are synchronous to clk.
module mpb_uart_tx #(
    parameter int unsigned DIV_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_en,
    input  logic [DIV_W-1:0]           baud_div,
    input  logic                       wr_en,
    input  logic [mpt_pkg::DATA_W-1:0] wr_data,
    input  logic                       mpb_wr,
    input  logic                       mpb_val,
    input  logic                       clr_empty,
    input  logic                       xfer_wr,
    input  logic                       xfer_dis_sel,
    input  logic                       xfer_cnt_nz,
    input  logic                       port_dir,
    input  logic                       port_dat,
    output logic                       txd,
    output logic                       empty_flag,
    output logic                       end_flag,
    output logic                       txi_req
);
    import mpt_pkg::*;

    logic   sh_load;
    logic   sh_busy;
    logic   sh_done;
    logic   sh_txd;
    frame_t sh_frame;

    mpt_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (tx_en),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .mpb_wr       (mpb_wr),
        .mpb_val      (mpb_val),
        .clr_empty    (clr_empty),
        .xfer_wr      (xfer_wr),
        .xfer_dis_sel (xfer_dis_sel),
        .xfer_cnt_nz  (xfer_cnt_nz),
        .sh_busy      (sh_busy),
        .sh_done      (sh_done),
        .sh_load      (sh_load),
        .sh_frame     (sh_frame),
        .empty_flag   (empty_flag),
        .end_flag     (end_flag)
    );

    mpt_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tx_en),
        .div    (baud_div),
        .load   (sh_load),
        .frame  (sh_frame),
        .busy   (sh_busy),
        .done   (sh_done),
        .sh_txd (sh_txd)
    );

    // Line source: the shifter when enabled, otherwise the port path (pulled high).
    always_comb begin
        if (tx_en)         txd = sh_txd;
        else if (port_dir) txd = port_dat;
        else               txd = 1'b1;
    end

    assign txi_req = tx_en && empty_flag;
endmodule

// File: rtl/mpb_uart_tx_chk.sv
// Checker for mpb_uart_tx: port-level timing rules, bound into every instance.
module mpb_uart_tx_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tx_en,
    input logic [DIV_W-1:0]           baud_div,
    input logic                       wr_en,
    input logic [mpt_pkg::DATA_W-1:0] wr_data,
    input logic                       mpb_wr,
    input logic                       mpb_val,
    input logic                       clr_empty,
    input logic                       xfer_wr,
    input logic                       xfer_dis_sel,
    input logic                       xfer_cnt_nz,
    input logic                       port_dir,
    input logic                       port_dat,
    input logic                       txd,
    input logic                       empty_flag,
    input logic                       end_flag,
    input logic                       txi_req
);
    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && port_dir && !port_dat) |-> !txd);

    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !port_dir) |-> txd);

    p_off_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (empty_flag && end_flag));

    p_preamble_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |=> txd);

    p_pending_no_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !empty_flag) |-> !end_flag);

    p_clear_drops_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && clr_empty && empty_flag) |=> !end_flag);

    p_refill_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $rose(empty_flag)) |-> txi_req);

    p_engine_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && empty_flag && xfer_wr && xfer_dis_sel && !clr_empty) |=> empty_flag);
endmodule

bind mpb_uart_tx mpb_uart_tx_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_mpb_uart_tx.sv
// Self-checking bench for mpb_uart_tx: directed corners plus seeded random bursts.
module sim_mpb_uart_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NFR        = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [7:0] baud_div;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       mpb_wr = 1'b0;
    logic       mpb_val = 1'b0;
    logic       clr_empty = 1'b0;
    logic       xfer_wr = 1'b0;
    logic       xfer_dis_sel = 1'b0;
    logic       xfer_cnt_nz = 1'b0;
    logic       port_dir = 1'b0;
    logic       port_dat = 1'b1;
    logic       txd, empty_flag, end_flag, txi_req;

    int cur_div = 4;
    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_d [64];
    logic       exp_m [64];
    logic [7:0] got_d [64];
    logic       got_m [64];
    int exp_n = 0;
    int got_n = 0;

    assign baud_div = cur_div[7:0];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpb_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_div(baud_div),
        .wr_en(wr_en), .wr_data(wr_data), .mpb_wr(mpb_wr), .mpb_val(mpb_val),
        .clr_empty(clr_empty), .xfer_wr(xfer_wr), .xfer_dis_sel(xfer_dis_sel),
        .xfer_cnt_nz(xfer_cnt_nz), .port_dir(port_dir), .port_dat(port_dat),
        .txd(txd), .empty_flag(empty_flag), .end_flag(end_flag), .txi_req(txi_req)
    );

    function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic m);
        return {1'b1, m, d, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Hands a byte over by software; checks the finished flag dropped (R5).
    task automatic send_sw(input logic [7:0] d, input logic m);
        while (!empty_flag) @(negedge clk);
        wr_en = 1'b1; wr_data = d; mpb_wr = 1'b1; mpb_val = m;
        @(negedge clk);
        wr_en = 1'b0; mpb_wr = 1'b0; clr_empty = 1'b1;
        @(negedge clk);
        clr_empty = 1'b0;
        chk(end_flag == 1'b0, "R5 end cleared by hand-over", end_flag, 0);
        exp_d[exp_n] = d; exp_m[exp_n] = m; exp_n++;
    endtask

    // Waits for the finished flag; every expected frame must already be on the line (R5).
    task automatic flush();
        while (!end_flag) @(negedge clk);
        chk(got_n == exp_n, "R5 end only after last stop", got_n, exp_n);
    endtask

    // Line monitor: decodes frames at bit centres, drops frames cut by disable.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && tx_en && !txd) begin
                logic [10:0] f;
                bit ab;
                ab = 1'b0;
                repeat (cur_div / 2) begin @(negedge clk); #1; end
                f[0] = txd;
                if (!tx_en) ab = 1'b1;
                for (int i = 1; i < NFR; i++) begin
                    repeat (cur_div) begin @(negedge clk); #1; end
                    f[i] = txd;
                    if (!tx_en) ab = 1'b1;
                end
                if (!ab) begin
                    chk(f[0] == 1'b0, "R1 start bit", f[0], 0);
                    chk(f[10] == 1'b1, "R1 stop bit", f[10], 1);
                    if (got_n < 64) begin
                        got_d[got_n] = f[8:1];
                        got_m[got_n] = f[9];
                    end
                    got_n++;
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int bad;
        int base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        chk(empty_flag == 1'b1, "R4 reset empty", empty_flag, 1);
        chk(end_flag == 1'b1, "R5 reset end", end_flag, 1);
        chk(txi_req == 1'b0, "R6 no request while off", txi_req, 0);
        chk(txd == 1'b1, "R8 released line high", txd, 1);

        // Break through the port path.
        port_dir = 1'b1; port_dat = 1'b0;
        @(negedge clk);
        chk(txd == 1'b0, "R8 break low", txd, 0);
        port_dat = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R8 port high", txd, 1);
        port_dir = 1'b0;

        // Startup frame of ones, with a byte handed over at once (div 4).
        cur_div = 4;
        @(negedge clk);
        tx_en = 1'b1; wr_en = 1'b1; wr_data = 8'h96; mpb_wr = 1'b1; mpb_val = 1'b1;
        bad = 0;
        for (int k = 1; k <= 45; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk(txi_req == 1'b1, "R6 request when empty", txi_req, 1);
                chk(end_flag == 1'b0, "R5 end cleared on enable", end_flag, 0);
                wr_en = 1'b0; mpb_wr = 1'b0; clr_empty = 1'b1;
            end
            if (k == 2) begin
                clr_empty = 1'b0;
                chk(txi_req == 1'b0, "R6 request drops when full", txi_req, 0);
            end
            if (!txd) bad++;
        end
        chk(bad == 0, "R3 line high for one frame", bad, 0);
        @(negedge clk);
        chk(txd == 1'b0, "R3 start bit right after idle frame", txd, 0);
        chk(empty_flag == 1'b1, "R4 reload frees holding register", empty_flag, 1);
        chk(end_flag == 1'b0, "R5 end low while shifting", end_flag, 0);
        exp_d[exp_n] = 8'h96; exp_m[exp_n] = 1'b1; exp_n++;
        flush();

        // Random back-to-back burst (div 3).
        cur_div = 3;
        for (int i = 0; i < 16; i++) send_sw(8'($urandom), 1'($urandom));
        flush();

        // Transfer engine: two blocked modes, then the allowed one (div 2).
        cur_div = 2;
        @(negedge clk);
        xfer_wr = 1'b1; wr_data = 8'hA5; xfer_dis_sel = 1'b1; xfer_cnt_nz = 1'b1;
        @(negedge clk);
        xfer_wr = 1'b0;
        chk(empty_flag == 1'b1, "R7 disable-select blocks clear", empty_flag, 1);
        xfer_wr = 1'b1; wr_data = 8'h5A; xfer_dis_sel = 1'b0; xfer_cnt_nz = 1'b0;
        @(negedge clk);
        xfer_wr = 1'b0;
        chk(empty_flag == 1'b1, "R7 zero count blocks clear", empty_flag, 1);
        base = got_n;
        repeat (40) @(negedge clk);
        chk(got_n == base, "R7 no frame from blocked writes", got_n, base);
        chk(end_flag == 1'b1, "R7 end stays set", end_flag, 1);
        mpb_wr = 1'b1; mpb_val = 1'b0;
        @(negedge clk);
        mpb_wr = 1'b0;
        xfer_wr = 1'b1; wr_data = 8'h3C; xfer_cnt_nz = 1'b1;
        @(negedge clk);
        xfer_wr = 1'b0;
        chk(empty_flag == 1'b0, "R7 engine clears flag", empty_flag, 0);
        exp_d[exp_n] = 8'h3C; exp_m[exp_n] = 1'b0; exp_n++;
        flush();

        // Shortest bit period and edge data values.
        cur_div = 1;
        send_sw(8'h00, 1'b1);
        send_sw(8'hFF, 1'b0);
        send_sw(8'h01, 1'b1);
        flush();

        // More random frames at a longer period.
        cur_div = 5;
        for (int i = 0; i < 6; i++) send_sw(8'($urandom), 1'($urandom));
        flush();

        // Frame contents against the bench model.
        chk(got_n == exp_n, "R1 frame count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < 64; i++) begin
            logic [10:0] e;
            e = exp_frame(exp_d[i], exp_m[i]);
            chk(got_d[i] == e[8:1], "R1 data bits", got_d[i], e[8:1]);
            chk(got_m[i] == e[9], "R2 marker bit", got_m[i], e[9]);
        end

        // Disable in mid-frame, then hold a break.
        cur_div = 8;
        send_sw(8'h55, 1'b1);
        exp_n--;
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(empty_flag == 1'b1, "R9 empty set after disable", empty_flag, 1);
        chk(end_flag == 1'b1, "R9 end set after disable", end_flag, 1);
        chk(txd == 1'b1, "R9 frame aborted, line released", txd, 1);
        port_dir = 1'b1; port_dat = 1'b0;
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (txd) bad++;
        end
        chk(bad == 0, "R8 break held", bad, 0);
        port_dat = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R8 break released", txd, 1);

        summary();
        $finish;
    end
endmodule